// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block holds a small, fully associative set of recent address translations. Each one maps a virtual page number to a physical page number and carries the context identifier of the process that owns it. A requester presents a virtual page number together with the context identifier currently in force. When a valid entry matches both values, the physical page number comes back combinationally in the same cycle. Because entries keep their context tag, switching processes only means driving a different context identifier. No entries have to be discarded.

When a lookup misses and no refill is already outstanding, the block captures the page number and context and raises a request to an external table walker. The request holds steady until the walker answers. A good answer is written into the lowest-numbered empty slot. If every slot is occupied, the slot under a round-robin pointer is overwritten instead. A fault answer writes nothing and is passed back to the requester as a translation fault. Two invalidation commands keep the cache consistent after table edits. One empties every slot. The other empties only the slots that belong to one named context.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every slot is empty: every lookup misses, `lk_ppn` reads zero and `walk_req` is low.
- R2: A lookup whose page number and current context both equal those of a valid slot asserts `lk_hit` and drives that slot's physical page number on `lk_ppn` in the same cycle, without raising a walk.
- R3: A slot only hits for the context that installed it. Changing `cur_ctx` leaves slots of other contexts intact, so two contexts can hold different translations for the same page number.
- R4: A missing lookup while no walk is outstanding raises `walk_req` from the next cycle, with `walk_vpn`/`walk_ctx` equal to the missing page number and context. The request stays asserted and unchanged until `walk_done`.
- R5: A `walk_done` with `walk_fault` low ends the walk and installs `walk_ppn` under the captured page number and context. A lookup of that pair hits from the next cycle.
- R6: A `walk_done` with `walk_fault` high asserts `xlat_fault` in that cycle, ends the walk and installs nothing.
- R7: An install picks the lowest-numbered empty slot. When all slots are valid it overwrites the slot under a round-robin pointer. The pointer starts at slot 0 after reset and moves one past each overwritten slot, wrapping at the end.
- R8: `flush_cmd` = 2'b01 empties every slot at the next clock edge.
- R9: `flush_cmd` = 2'b10 empties only the slots whose context equals `flush_ctx`. Codes 2'b00 and 2'b11 do nothing.
- R10: An install in the same cycle as a flush is applied after the flush, so the new translation remains valid.
- R11: Misses seen while a walk is outstanding start no second walk and do not alter `walk_vpn`/`walk_ctx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_ctx | input | CTX_W | Context identifier currently in force |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | PPN_W | Translated physical page number, zero on miss |
| walk_req | output | 1 | Refill walk outstanding |
| walk_vpn | output | VPN_W | Page number being walked |
| walk_ctx | output | CTX_W | Context of the walk |
| walk_done | input | 1 | Walker answer valid this cycle |
| walk_fault | input | 1 | Walker found no valid mapping |
| walk_ppn | input | PPN_W | Physical page number from the walker |
| xlat_fault | output | 1 | Translation fault forwarded to the requester |
| flush_cmd | input | 2 | 00 none, 01 empty all, 10 empty one context, 11 none |
| flush_ctx | input | CTX_W | Context targeted by the selective flush |

## Verification
On every cycle, the checker confirms that at most one slot matches a lookup. It also confirms that an outstanding walk request stays steady until answered, that a fault only appears as the answer to a live walk, and that a freshly installed pair hits on the following cycle, even when a flush shared that cycle. The choice of victim slot, the round-robin order once the cache is full, and which slots each flush empties can only be seen through scenario sequences. Those sequences install known pairs, overflow the cache, flush, and then probe for hits and misses.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

   typedef enum logic [1:0] {
      FLUSH_NONE = 2'b00,
      FLUSH_ALL  = 2'b01,
      FLUSH_CTX  = 2'b10,
      FLUSH_RSVD = 2'b11
   } flush_cmd_e;

endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 36,
   parameter int PPN_W   = 36,
   parameter int CTX_W   = 12
) (
   input  logic                             lk_valid,
   input  logic [VPN_W-1:0]                 lk_vpn,
   input  logic [CTX_W-1:0]                 cur_ctx,
   input  logic [ENTRIES-1:0]               slot_valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]    slot_vpn,
   input  logic [ENTRIES-1:0][CTX_W-1:0]    slot_ctx,
   input  logic [ENTRIES-1:0][PPN_W-1:0]    slot_ppn,
   output logic [ENTRIES-1:0]               hit_vec,
   output logic                             hit,
   output logic [PPN_W-1:0]                 ppn
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = lk_valid && slot_valid[i]
                          && (slot_vpn[i] == lk_vpn)
                          && (slot_ctx[i] == cur_ctx);
   end

   assign hit = |hit_vec;

   always_comb begin
      ppn = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         ppn = ppn | (hit_vec[i] ? slot_ppn[i] : '0);
      end
   end

endmodule

// File: rtl/ctx_tlb_flush.sv
module ctx_tlb_flush #(
   parameter int ENTRIES = 16,
   parameter int CTX_W   = 12
) (
   input  logic [1:0]                    flush_cmd,
   input  logic [CTX_W-1:0]              flush_ctx,
   input  logic [ENTRIES-1:0][CTX_W-1:0] slot_ctx,
   output logic [ENTRIES-1:0]            kill_vec
);
   import ctx_tlb_pkg::*;

   flush_cmd_e cmd;
   assign cmd = flush_cmd_e'(flush_cmd);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
      assign kill_vec[i] = (cmd == FLUSH_ALL)
                        || ((cmd == FLUSH_CTX) && (slot_ctx[i] == flush_ctx));
   end

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] slot_valid,
   input  logic [IDX_W-1:0]   rr_ptr,
   output logic [IDX_W-1:0]   victim,
   output logic               full
);

   assign full = &slot_valid;

   always_comb begin
      victim = rr_ptr;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!slot_valid[i]) begin
            victim = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 36,
   parameter int PPN_W   = 36,
   parameter int CTX_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTX_W-1:0] cur_ctx,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   output logic [CTX_W-1:0] walk_ctx,
   input  logic             walk_done,
   input  logic             walk_fault,
   input  logic [PPN_W-1:0] walk_ppn,
   output logic             xlat_fault,
   input  logic [1:0]       flush_cmd,
   input  logic [CTX_W-1:0] flush_ctx
);

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ctx_tlb: ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || CTX_W < 1) begin : g_bad_width
      $error("ctx_tlb: field widths must be positive");
   end

   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [ENTRIES-1:0][CTX_W-1:0] ctx_q;
   logic [IDX_W-1:0]              rr_q;
   logic                          busy_q;
   logic [VPN_W-1:0]              req_vpn_q;
   logic [CTX_W-1:0]              req_ctx_q;

   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] kill_vec;
   logic [ENTRIES-1:0] valid_post;
   logic [IDX_W-1:0]   victim;
   logic               full;
   logic               install;
   logic               launch;

   ctx_tlb_match #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
   ) u_match (
      .lk_valid   (lk_valid),
      .lk_vpn     (lk_vpn),
      .cur_ctx    (cur_ctx),
      .slot_valid (valid_q),
      .slot_vpn   (vpn_q),
      .slot_ctx   (ctx_q),
      .slot_ppn   (ppn_q),
      .hit_vec    (hit_vec),
      .hit        (lk_hit),
      .ppn        (lk_ppn)
   );

   ctx_tlb_flush #(
      .ENTRIES(ENTRIES), .CTX_W(CTX_W)
   ) u_flush (
      .flush_cmd (flush_cmd),
      .flush_ctx (flush_ctx),
      .slot_ctx  (ctx_q),
      .kill_vec  (kill_vec)
   );

   assign valid_post = valid_q & ~kill_vec;

   ctx_tlb_victim #(
      .ENTRIES(ENTRIES)
   ) u_victim (
      .slot_valid (valid_post),
      .rr_ptr     (rr_q),
      .victim     (victim),
      .full       (full)
   );

   assign install    = busy_q && walk_done && !walk_fault;
   assign xlat_fault = busy_q && walk_done && walk_fault;
   assign launch     = !busy_q && lk_valid && !lk_hit;

   assign walk_req = busy_q;
   assign walk_vpn = req_vpn_q;
   assign walk_ctx = req_ctx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         vpn_q   <= '0;
         ppn_q   <= '0;
         ctx_q   <= '0;
         rr_q    <= '0;
      end else begin
         valid_q <= valid_post;
         if (install) begin
            valid_q[victim] <= 1'b1;
            vpn_q[victim]   <= req_vpn_q;
            ctx_q[victim]   <= req_ctx_q;
            ppn_q[victim]   <= walk_ppn;
            if (full) begin
               rr_q <= victim + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         req_vpn_q <= '0;
         req_ctx_q <= '0;
      end else if (launch) begin
         busy_q    <= 1'b1;
         req_vpn_q <= lk_vpn;
         req_ctx_q <= cur_ctx;
      end else if (busy_q && walk_done) begin
         busy_q    <= 1'b0;
      end
   end

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 36,
   parameter int PPN_W   = 36,
   parameter int CTX_W   = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CTX_W-1:0]   cur_ctx,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic               lk_hit,
   input logic               walk_req,
   input logic [VPN_W-1:0]   walk_vpn,
   input logic [CTX_W-1:0]   walk_ctx,
   input logic               walk_done,
   input logic               walk_fault,
   input logic               xlat_fault,
   input logic [1:0]         flush_cmd,
   input logic [ENTRIES-1:0] hit_vec
);

   // R2: a lookup resolves to at most one slot
   assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R4: a miss with no walk pending launches one carrying that page
   assert_walk_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_hit && !walk_req)
      |=> (walk_req && walk_vpn == $past(lk_vpn) && walk_ctx == $past(cur_ctx)));

   // R4, R11: a pending request holds until answered
   assert_walk_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_done)
      |=> (walk_req && $stable(walk_vpn) && $stable(walk_ctx)));

   // R6: a fault only appears as the answer to a live walk
   assert_fault_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_fault |-> (walk_req && walk_done && walk_fault));

   // R5, R10: an installed pair hits next cycle, flush or not
   assert_install_hits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && walk_done && !walk_fault)
      |=> (!(lk_valid && lk_vpn == $past(walk_vpn) && cur_ctx == $past(walk_ctx))
           || lk_hit));

   // R8: after a full flush with no install, nothing hits
   assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_cmd == 2'b01 && !(walk_req && walk_done && !walk_fault))
      |=> !lk_hit);

   // R2: a hit needs a lookup
   assert_hit_needs_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid);

endmodule

bind ctx_tlb ctx_tlb_chk #(
   .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cur_ctx    (cur_ctx),
   .lk_valid   (lk_valid),
   .lk_vpn     (lk_vpn),
   .lk_hit     (lk_hit),
   .walk_req   (walk_req),
   .walk_vpn   (walk_vpn),
   .walk_ctx   (walk_ctx),
   .walk_done  (walk_done),
   .walk_fault (walk_fault),
   .xlat_fault (xlat_fault),
   .flush_cmd  (flush_cmd),
   .hit_vec    (hit_vec)
);

// File: tb/ctx_tlb_tb.sv
module ctx_tlb_tb;

   localparam int ENTRIES = 16;
   localparam int VPN_W   = 36;
   localparam int PPN_W   = 36;
   localparam int CTX_W   = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CTX_W-1:0] cur_ctx = '0;
   logic             lk_valid = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic             lk_hit;
   logic [PPN_W-1:0] lk_ppn;
   logic             walk_req;
   logic [VPN_W-1:0] walk_vpn;
   logic [CTX_W-1:0] walk_ctx;
   logic             walk_done = 1'b0;
   logic             walk_fault = 1'b0;
   logic [PPN_W-1:0] walk_ppn = '0;
   logic             xlat_fault;
   logic [1:0]       flush_cmd = 2'b00;
   logic [CTX_W-1:0] flush_ctx = '0;

   always #5 clk = ~clk;

   ctx_tlb #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cur_ctx(cur_ctx),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ctx(walk_ctx),
      .walk_done(walk_done), .walk_fault(walk_fault), .walk_ppn(walk_ppn),
      .xlat_fault(xlat_fault), .flush_cmd(flush_cmd), .flush_ctx(flush_ctx)
   );

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   typedef struct {
      logic             hit;
      logic [PPN_W-1:0] ppn;
      string            tag;
   } exp_t;

   exp_t sb_q[$];
   event sample_ev;

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected item and compares with the outputs
   initial begin
      forever begin
         @(sample_ev);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(lk_hit == e.hit, {e.tag, " hit"}, 64'(lk_hit), 64'(e.hit));
            chk(lk_ppn == e.ppn, {e.tag, " ppn"}, 64'(lk_ppn), 64'(e.ppn));
         end
      end
   end

   // driver: one lookup cycle; lk_valid spans one rising edge
   task automatic lookup(input logic [CTX_W-1:0] ctx, input logic [VPN_W-1:0] vpn,
                         input logic exp_hit, input logic [PPN_W-1:0] exp_ppn,
                         input string tag);
      exp_t e;
      @(negedge clk);
      cur_ctx  = ctx;
      lk_vpn   = vpn;
      lk_valid = 1'b1;
      e.hit = exp_hit;
      e.ppn = exp_hit ? exp_ppn : '0;
      e.tag = tag;
      sb_q.push_back(e);
      #1 ->sample_ev;
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   // miss, check the launched walk, answer it (optionally with a flush)
   task automatic refill(input logic [CTX_W-1:0] ctx, input logic [VPN_W-1:0] vpn,
                         input logic [PPN_W-1:0] ppn, input logic [1:0] fcmd,
                         input logic [CTX_W-1:0] fctx, input string tag);
      lookup(ctx, vpn, 1'b0, '0, {tag, " miss"});
      chk(walk_req == 1'b1, "R4 walk_req raised", 64'(walk_req), 64'd1);
      chk(walk_vpn == vpn, "R4 walk_vpn", 64'(walk_vpn), 64'(vpn));
      chk(walk_ctx == ctx, "R4 walk_ctx", 64'(walk_ctx), 64'(ctx));
      @(negedge clk);
      walk_done  = 1'b1;
      walk_fault = 1'b0;
      walk_ppn   = ppn;
      flush_cmd  = fcmd;
      flush_ctx  = fctx;
      @(posedge clk);
      #1;
      walk_done = 1'b0;
      flush_cmd = 2'b00;
      chk(walk_req == 1'b0, "R5 walk ends", 64'(walk_req), 64'd0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done_flag) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(walk_req == 1'b0, "R1 walk_req in reset", 64'(walk_req), 64'd0);
      rst_n = 1'b1;
      lookup(12'd1, 36'h5, 1'b0, '0, "R1 empty after reset");
      // that miss launched a walk; answer with a fault to clear it (R6)
      @(negedge clk);
      walk_done = 1'b1; walk_fault = 1'b1;
      #1 chk(xlat_fault == 1'b1, "R6 fault forwarded", 64'(xlat_fault), 64'd1);
      @(posedge clk);
      #1 walk_done = 1'b0; walk_fault = 1'b0;

      // R5, R2: install and hit
      refill(12'd1, 36'h10, 36'hA0, 2'b00, '0, "R5 first");
      lookup(12'd1, 36'h10, 1'b1, 36'hA0, "R2 hit ctx1");

      // R3: same page, other context
      refill(12'd2, 36'h10, 36'hB0, 2'b00, '0, "R3 other ctx");
      lookup(12'd1, 36'h10, 1'b1, 36'hA0, "R3 ctx1 kept");
      lookup(12'd2, 36'h10, 1'b1, 36'hB0, "R3 ctx2 own");

      // R6, R11: fault path and misses during an outstanding walk
      lookup(12'd1, 36'h20, 1'b0, '0, "R6 miss");
      chk(walk_vpn == 36'h20, "R4 walk_vpn 20", 64'(walk_vpn), 64'h20);
      lookup(12'd7, 36'h99, 1'b0, '0, "R11 miss while busy");
      chk(walk_vpn == 36'h20, "R11 walk_vpn unchanged", 64'(walk_vpn), 64'h20);
      chk(walk_ctx == 12'd1, "R11 walk_ctx unchanged", 64'(walk_ctx), 64'd1);
      @(negedge clk);
      walk_done = 1'b1; walk_fault = 1'b1; walk_ppn = 36'hDEAD;
      #1 chk(xlat_fault == 1'b1, "R6 xlat_fault", 64'(xlat_fault), 64'd1);
      @(posedge clk);
      #1 walk_done = 1'b0; walk_fault = 1'b0;
      chk(xlat_fault == 1'b0, "R6 fault one cycle", 64'(xlat_fault), 64'd0);
      refill(12'd1, 36'h20, 36'hC0, 2'b00, '0, "R6 nothing installed");

      // R7: fill slots 3..15 with context 3
      for (int i = 3; i < ENTRIES; i++) begin
         refill(12'd3, 36'(36'h100 + i), 36'(36'h200 + i), 2'b00, '0, "R7 fill");
      end
      // full: round robin evicts 0, then 1, then 2
      refill(12'd3, 36'h300, 36'h400, 2'b00, '0, "R7 evict slot0");
      refill(12'd1, 36'h10, 36'hA1, 2'b00, '0, "R7 slot0 gone");
      refill(12'd2, 36'h10, 36'hB1, 2'b00, '0, "R7 slot1 gone");
      lookup(12'd1, 36'h20, 1'b0, '0, "R7 slot2 gone");
      @(negedge clk);
      walk_done = 1'b1; walk_fault = 1'b1;
      @(posedge clk);
      #1 walk_done = 1'b0; walk_fault = 1'b0;
      lookup(12'd3, 36'h300, 1'b1, 36'h400, "R7 new in slot0");
      lookup(12'd1, 36'h10, 1'b1, 36'hA1, "R7 new in slot1");
      lookup(12'd3, 36'h103, 1'b1, 36'h203, "R7 slot3 kept");

      // R9: codes 00 and 11 do nothing, 10 removes context 3 only
      @(negedge clk); flush_cmd = 2'b11; flush_ctx = 12'd3;
      @(negedge clk); flush_cmd = 2'b00;
      lookup(12'd3, 36'h105, 1'b1, 36'h205, "R9 code 11 no effect");
      @(negedge clk); flush_cmd = 2'b10; flush_ctx = 12'd3;
      @(negedge clk); flush_cmd = 2'b00;
      lookup(12'd1, 36'h10, 1'b1, 36'hA1, "R9 ctx1 survives");
      lookup(12'd2, 36'h10, 1'b1, 36'hB1, "R9 ctx2 survives");
      refill(12'd3, 36'h105, 36'h505, 2'b00, '0, "R9 ctx3 removed");
      lookup(12'd3, 36'h105, 1'b1, 36'h505, "R9 reinstall");

      // R10: install coincides with flush-all
      refill(12'd4, 36'h700, 36'h800, 2'b01, '0, "R10 refill with flush");
      lookup(12'd4, 36'h700, 1'b1, 36'h800, "R10 survives flush");
      // R8: everything else gone
      refill(12'd1, 36'h10, 36'hA2, 2'b00, '0, "R8 ctx1 flushed");
      refill(12'd3, 36'h105, 36'h506, 2'b00, '0, "R8 ctx3 flushed");
      lookup(12'd3, 36'h105, 1'b1, 36'h506, "R8 refilled");

      repeat (2) @(negedge clk);
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule